// File: doc/BRIEF.md
# Host Register Access Firewall

This block sits between a host bus register port and a management controller's internal register file. It decides, access by access, whether a host read or write may reach the register file. Each address falls into one of four trust classes, taken from parameter ranges. General registers are open to the host. Protected registers are writable only while unlocked. The exposed read-only window can be read but not written. Secure registers are closed to the host in both directions. Any address that no range claims is treated as secure.

The management side owns a one-way write lock for the protected class. The host has no path to the lock bit. A safe-mode strap reopens protected writes without clearing the lock. A refused read returns zeros and flags an error in the same cycle. A refused write never reaches the register file, and it sets a sticky violation bit that only the management side can clear.

Top module: `host_reg_firewall`

## Requirements
- R1: A host read or write to the general range (default 0x00-0x3F) is forwarded in the same cycle. It raises `rf_req`, copies the address and write data, and returns `rf_rdata` on reads with `host_err` low.
- R2: A host write to the protected range (default 0x40-0x5F) is forwarded while the lock is clear. While the lock is set and safe mode is off, the write is refused. Reads of the protected range are always forwarded.
- R3: `lock_q` changes only on a management lock write (`mgmt_lock_we`), which loads `mgmt_lock_val` at the next edge. No host access changes it.
- R4: While `safe_mode` is high, host writes to the protected range are forwarded whatever the lock state. The lock value itself is kept.
- R5: A host read or write to the secure range (default 0x80-0xFF) is always refused.
- R6: An address outside every defined range is decoded as secure. When the range parameters leave gaps, accesses in those gaps behave as in R5.
- R7: The exposed read-only range (default 0x60-0x7F) forwards host reads and refuses host writes.
- R8: A refused access keeps `rf_req` low and raises `host_err` in the same cycle. A refused read returns `host_rdata` = 0.
- R9: A refused write sets `viol_q` at the next edge. `viol_q` stays set until the management side pulses `viol_clr`. A refused write in the same cycle as the clear wins, so the bit stays set.
- R10: A management lock write takes priority over a host access in the same cycle. The host write to the protected range is judged against the new lock value.
- R11: After reset, `lock_q` and `viol_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| safe_mode | input | 1 | Safe-mode strap; reopens protected writes |
| host_req | input | 1 | Host access valid |
| host_we | input | 1 | Host access is a write |
| host_addr | input | AW | Host register address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data returned to the host, zero when refused |
| host_err | output | 1 | Host access refused |
| rf_req | output | 1 | Forwarded access to the register file |
| rf_we | output | 1 | Forwarded access is a write |
| rf_addr | output | AW | Forwarded address |
| rf_wdata | output | DW | Forwarded write data |
| rf_rdata | input | DW | Register file read data |
| mgmt_lock_we | input | 1 | Management write of the lock bit |
| mgmt_lock_val | input | 1 | Lock value written by management |
| viol_clr | input | 1 | Management clear of the violation bit |
| lock_q | output | 1 | Current lock state |
| viol_q | output | 1 | Sticky refused-write flag |

## Verification
Directed cases cover each class boundary. They write the protected range before and after locking, which tells the lock gate apart from the class decode. They repeat the locked write with safe mode on, which isolates the strap. They issue a lock set and a lock clear in the same cycle as a protected write, which shows whether the new or the old lock value decides. Refused writes issued against and after a clear show the stickiness and the set-over-clear priority. A long seeded random mix of addresses, directions, strap values and management pulses then hits every class under every lock state, checked against a bench model of the permit rules.

// File: rtl/host_reg_firewall.sv
module host_reg_firewall #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] GEN_LO  = 'h00,
  parameter logic [AW-1:0] GEN_HI  = 'h3F,
  parameter logic [AW-1:0] PROT_LO = 'h40,
  parameter logic [AW-1:0] PROT_HI = 'h5F,
  parameter logic [AW-1:0] RO_LO   = 'h60,
  parameter logic [AW-1:0] RO_HI   = 'h7F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          safe_mode,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_err,
  output logic          rf_req,
  output logic          rf_we,
  output logic [AW-1:0] rf_addr,
  output logic [DW-1:0] rf_wdata,
  input  logic [DW-1:0] rf_rdata,
  input  logic          mgmt_lock_we,
  input  logic          mgmt_lock_val,
  input  logic          viol_clr,
  output logic          lock_q,
  output logic          viol_q
);

  logic in_gen, in_prot, in_ro, lock_eff, rd_ok, wr_ok, permit, bad_wr;

  assign in_gen  = (host_addr >= GEN_LO)  && (host_addr <= GEN_HI);
  assign in_prot = !in_gen && (host_addr >= PROT_LO) && (host_addr <= PROT_HI);
  assign in_ro   = !in_gen && !in_prot && (host_addr >= RO_LO) && (host_addr <= RO_HI);

  assign lock_eff = mgmt_lock_we ? mgmt_lock_val : lock_q;

  assign rd_ok  = in_gen || in_prot || in_ro;
  assign wr_ok  = in_gen || (in_prot && (safe_mode || !lock_eff));
  assign permit = host_we ? wr_ok : rd_ok;
  assign bad_wr = host_req && host_we && !wr_ok;

  assign rf_req     = host_req && permit;
  assign rf_we      = rf_req && host_we;
  assign rf_addr    = host_addr;
  assign rf_wdata   = host_wdata;
  assign host_err   = host_req && !permit;
  assign host_rdata = (rf_req && !host_we) ? rf_rdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      lock_q <= lock_eff;
      viol_q <= bad_wr || (viol_q && !viol_clr);
    end
  end

endmodule

module host_reg_firewall_chk #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] PROT_LO = 'h40,
  parameter logic [AW-1:0] PROT_HI = 'h5F,
  parameter logic [AW-1:0] RO_LO   = 'h60,
  parameter logic [AW-1:0] RO_HI   = 'h7F
) (
  input logic          clk,
  input logic          rst_n,
  input logic          safe_mode,
  input logic          host_req,
  input logic          host_we,
  input logic [AW-1:0] host_addr,
  input logic [DW-1:0] host_rdata,
  input logic          host_err,
  input logic          rf_req,
  input logic          mgmt_lock_we,
  input logic          viol_clr,
  input logic          lock_q,
  input logic          viol_q
);

  p_lock_host_proof_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_lock_we |=> $stable(lock_q));

  p_locked_prot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && lock_q && !mgmt_lock_we && !safe_mode &&
     host_addr >= PROT_LO && host_addr <= PROT_HI) |-> !rf_req);

  p_ro_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && host_addr >= RO_LO && host_addr <= RO_HI) |-> !rf_req);

  p_refused_rd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_err && !host_we) |-> (host_rdata == '0));

  p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_err && rf_req));

  p_viol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_q && !viol_clr) |=> viol_q);

  p_viol_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_err && host_we) |=> viol_q);

endmodule

bind host_reg_firewall host_reg_firewall_chk #(
  .AW(AW), .DW(DW), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI), .RO_LO(RO_LO), .RO_HI(RO_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .safe_mode(safe_mode), .host_req(host_req),
  .host_we(host_we), .host_addr(host_addr), .host_rdata(host_rdata),
  .host_err(host_err), .rf_req(rf_req), .mgmt_lock_we(mgmt_lock_we),
  .viol_clr(viol_clr), .lock_q(lock_q), .viol_q(viol_q)
);

// File: tb/host_reg_firewall_bench.sv
module host_reg_firewall_bench;
  localparam int CLK_P = 10;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic safe_mode = 0, host_req = 0, host_we = 0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0, host_rdata, rf_wdata, rf_rdata;
  logic host_err, rf_req, rf_we;
  logic [AW-1:0] rf_addr;
  logic mgmt_lock_we = 0, mgmt_lock_val = 0, viol_clr = 0, lock_q, viol_q;

  int checks = 0, failures = 0;
  logic lock_m = 0, viol_m = 0;

  always #(CLK_P/2) clk = ~clk;
  assign rf_rdata = {24'hC3A5_5A, rf_addr};

  host_reg_firewall u_host_reg_firewall (.*);

  function automatic int cls(input logic [AW-1:0] a);
    if (a <= 8'h3F) return 0;
    if (a <= 8'h5F) return 1;
    if (a <= 8'h7F) return 2;
    return 3;
  endfunction

  function automatic string rq(input int c, input logic we);
    case (c)
      0: return "R1";
      1: return we ? "R2/R4/R10" : "R2";
      2: return "R7";
      default: return "R5/R6";
    endcase
  endfunction

  function automatic logic allowed(input int c, input logic we, input logic lk, input logic sm);
    if (!we) return c != 3;
    return c == 0 || (c == 1 && (sm || !lk));
  endfunction

  task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic op(input logic rq_i, input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic lwe, input logic lval, input logic clr, input logic sm);
    logic lk, ok;
    int c;
    @(negedge clk);
    host_req = rq_i; host_we = we; host_addr = a; host_wdata = d;
    mgmt_lock_we = lwe; mgmt_lock_val = lval; viol_clr = clr; safe_mode = sm;
    #1;
    c = cls(a);
    lk = lwe ? lval : lock_m;
    ok = rq_i && allowed(c, we, lk, sm);
    chk(rq(c, we), "rf_req", 64'(rf_req), 64'(ok));
    chk("R8", "host_err", 64'(host_err), 64'(rq_i && !ok));
    if (ok) begin
      chk(rq(c, we), "rf_we", 64'(rf_we), 64'(we));
      chk(rq(c, we), "rf_addr", 64'(rf_addr), 64'(a));
      if (we) chk(rq(c, we), "rf_wdata", 64'(rf_wdata), 64'(d));
    end
    if (rq_i && !we)
      chk(ok ? rq(c, we) : "R8", "host_rdata", 64'(host_rdata), ok ? 64'({24'hC3A5_5A, a}) : 64'(0));
    lock_m = lk;
    viol_m = (rq_i && we && !ok) || (viol_m && !clr);
    @(posedge clk); #1;
    chk("R3", "lock_q", 64'(lock_q), 64'(lock_m));
    chk("R9", "viol_q", 64'(viol_q), 64'(viol_m));
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_P * 2 + 1);
    chk("R11", "lock_q reset", 64'(lock_q), 0);
    chk("R11", "viol_q reset", 64'(viol_q), 0);
    rst_n = 1'b1;
    op(1, 1, 8'h3F, 32'h1111, 0, 0, 0, 0);
    op(1, 0, 8'h00, 0, 0, 0, 0, 0);
    op(1, 1, 8'h40, 32'h2222, 0, 0, 0, 0);
    op(1, 1, 8'h5F, 32'h3333, 1, 1, 0, 0);  // R10 lock set wins same cycle
    op(1, 0, 8'h50, 0, 0, 0, 0, 0);
    op(1, 1, 8'h41, 32'h4444, 0, 0, 0, 1);  // R4 safe mode bypass, lock kept
    op(1, 1, 8'h60, 32'h5, 0, 0, 1, 0);     // R9 refused write beats clear
    op(1, 0, 8'h7F, 0, 0, 0, 0, 0);
    op(0, 0, 8'h00, 0, 0, 0, 1, 0);         // R9 clear
    op(1, 0, 8'h80, 0, 0, 0, 0, 0);         // R5 read refused
    op(1, 1, 8'hFF, 32'h6, 0, 0, 0, 0);     // R6 top of space
    op(0, 0, 8'h00, 0, 0, 0, 0, 0);         // R9 sticky
    op(1, 1, 8'h42, 32'h7, 1, 0, 1, 0);     // R10 lock clear wins same cycle
    for (int i = 0; i < 3000; i++) begin
      op($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, 8'($urandom()), $urandom(),
         $urandom_range(0, 15) == 0, $urandom_range(0, 1) == 1,
         $urandom_range(0, 9) == 0, $urandom_range(0, 7) == 0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule